// File: doc/BRIEF.md
# Command and Data Line Inhibit Tracker

This block sits inside a memory-card host controller. It keeps the status bits that tell software whether the command line and the data lines are free. The command engine and the data engine send it single-cycle strobes: a command was issued, an end bit went out, a response ended (possibly with errors), a timeout occurred, the last block arrived, write CRC status came back, the host entered read-wait, the transfer stopped at a block gap or was told to continue. The block also watches the raw level of data line 0, which a card holds low while it is busy.

From these inputs the block keeps a command-inhibit flag, read-active and write-active flags, a data-line-active flag and a data-inhibit flag. When data-inhibit falls, it emits a one-cycle transfer-done pulse. After a write, the data lines only count as free once line 0 has been released for a set number of consecutive clocks. The same idle window ends a command that uses busy signalling. A synchronous software reset input clears all state.

Top module: `line_inhibit_tracker`

## Requirements
- R1: After `rst_n` is released, and on the clock after `soft_rst` is high, every status output is 0 and `xfer_done` stays 0 (a software reset produces no done pulse).
- R2: `cmd_issue` sets `cmd_inhibit` on the next clock. `auto_stop_issue` leaves `cmd_inhibit` unchanged.
- R3: With response type not 00, `rsp_end` clears `cmd_inhibit` on the next clock. It does not clear it when `rsp_crc_err`, `rsp_endbit_err` or `auto_stop_skip` is high with it, or when the response belongs to an outstanding automatic stop command.
- R4: With response type 00 (`cmd_rsp_type` = 2'b00 at issue), `cmd_end` clears `cmd_inhibit` on the next clock. With any other type, `cmd_end` leaves it set.
- R5: `cmd_timeout` never clears `cmd_inhibit`.
- R6: `cmd_end` of a command whose `cmd_kind` at issue is 2'b01 (read) sets `rd_active` and `dat_active`. For 2'b10 (write) it sets `wr_active` and `dat_active`.
- R7: During a read, `rd_last_blk` or `rd_wait` clears `dat_active`. `rd_active` stays set until `rd_drained` or `stop_gap` clears it.
- R8: During a write, `wr_crc_stat` or `stop_gap` clears `wr_active`. `dat_active` then falls only at the clock edge that samples `dat0` high for the 8th consecutive time; a low sample restarts the count.
- R9: `cont_req` after a `stop_gap` sets again the active flag of the interrupted direction, together with `dat_active`. `cont_req` without a preceding stop is ignored.
- R10: `dat_inhibit` is high while any of `dat_active`, `rd_active` or a command issued with `cmd_busy` is pending. A busy command stays pending from issue until 8 consecutive high `dat0` samples after its response end.
- R11: `xfer_done` is high for exactly the one cycle after `dat_inhibit` falls from 1 to 0, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous software reset of command and data tracking |
| cmd_issue | input | 1 | Software wrote the command-start byte |
| cmd_rsp_type | input | 2 | Response type of the issued command, 00 = none |
| cmd_kind | input | 2 | Data direction of the issued command: 00 none, 01 read, 10 write |
| cmd_busy | input | 1 | Issued command uses busy signalling on line 0 |
| auto_stop_issue | input | 1 | Automatic stop command sent by hardware |
| cmd_end | input | 1 | End bit of a command transmitted |
| rsp_end | input | 1 | End bit of a response received |
| rsp_crc_err | input | 1 | CRC error flagged with the response |
| rsp_endbit_err | input | 1 | End-bit error flagged with the response |
| auto_stop_skip | input | 1 | Automatic stop not executed, flagged with the response |
| cmd_timeout | input | 1 | Command response timeout |
| rd_last_blk | input | 1 | End bit of the last read block received |
| rd_drained | input | 1 | All read data taken from the buffer |
| wr_crc_stat | input | 1 | CRC status for the last write block received |
| rd_wait | input | 1 | Read-wait period entered |
| stop_gap | input | 1 | Transfer stopped at a block gap |
| cont_req | input | 1 | Continue request after a gap stop |
| dat0 | input | 1 | Raw level of data line 0, low = busy |
| cmd_inhibit | output | 1 | Command line in use |
| rd_active | output | 1 | Read transfer active |
| wr_active | output | 1 | Write transfer active |
| dat_active | output | 1 | Data lines in use |
| dat_inhibit | output | 1 | Commands using the data lines are blocked |
| xfer_done | output | 1 | One-cycle pulse on data-inhibit release |

## Verification
The hardest case to reach is the write busy release. Line 0 has to be held low through the CRC status, released, pulled low again partway through the idle window, and then released for exactly the full window. The bench drives `dat0` from the scenario task with counted clock steps. It samples `dat_active` one step before and at the edge where it must fall, so an off-by-one count or a missing restart on a low sample shows up as a wrong value at a known cycle. Responses that belong to an outstanding automatic stop are produced by a normal command followed by an automatic stop.

// File: rtl/lit_pkg.sv
package lit_pkg;

  typedef enum logic [1:0] {
    KIND_NONE = 2'b00,
    KIND_RD   = 2'b01,
    KIND_WR   = 2'b10,
    KIND_RSV  = 2'b11
  } xfer_kind_e;

  typedef enum logic [1:0] {
    DL_OFF  = 2'b00,
    DL_ON   = 2'b01,
    DL_WAIT = 2'b10
  } dl_state_e;

  localparam logic [1:0] RSP_TYPE_NONE = 2'b00;

  typedef struct packed {
    logic       rsp_none;
    xfer_kind_e kind;
  } cmd_ctx_t;

endpackage

// File: rtl/lit_idle_timer.sv
module lit_idle_timer #(
  parameter int IDLE_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic arm,
  input  logic dat0,
  output logic idle_done
);

  localparam int CW = (IDLE_CYCLES > 2) ? $clog2(IDLE_CYCLES) : 1;
  localparam logic [CW-1:0] CMAX = CW'(IDLE_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  // count consecutive released samples while armed; saturate at the last step
  always_comb begin
    cnt_en = 1'b1;
    cnt_d  = cnt_q;
    if (soft_rst || !arm || !dat0) begin
      cnt_d = '0;
    end else if (cnt_q != CMAX) begin
      cnt_d = cnt_q + CW'(1);
    end else begin
      cnt_en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign idle_done = arm && dat0 && (cnt_q == CMAX);

endmodule

// File: rtl/lit_cmd_track.sv
module lit_cmd_track
  import lit_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_rst,
  input  logic       cmd_issue,
  input  logic [1:0] cmd_rsp_type,
  input  logic [1:0] cmd_kind,
  input  logic       cmd_busy,
  input  logic       auto_stop_issue,
  input  logic       cmd_end,
  input  logic       rsp_end,
  input  logic       rsp_crc_err,
  input  logic       rsp_endbit_err,
  input  logic       auto_stop_skip,
  input  logic       cmd_timeout,
  input  logic       idle_done,
  output logic       cmd_inhibit,
  output logic       busy_pend,
  output logic       busy_arm,
  output logic       start_rd,
  output logic       start_wr
);

  cmd_ctx_t ctx_q, ctx_d;
  logic     cmdi_q, cmdi_d;
  logic     auto_q, auto_d;
  logic     busy_q, busy_d;
  logic     barm_q, barm_d;
  logic     own_rsp, own_end, rsp_clean;

  assign own_rsp   = rsp_end && !auto_q;
  assign own_end   = cmd_end && !auto_q;
  assign rsp_clean = !rsp_crc_err && !rsp_endbit_err && !auto_stop_skip;

  always_comb begin
    ctx_d  = ctx_q;
    cmdi_d = cmdi_q;
    auto_d = auto_q;
    busy_d = busy_q;
    barm_d = barm_q;

    // release paths; a timeout has none
    if (own_rsp && rsp_clean) cmdi_d = 1'b0;
    if (own_end && ctx_q.rsp_none) cmdi_d = 1'b0;

    // automatic stop runs beside the inhibit, never touching it
    if (auto_q && (rsp_end || cmd_timeout)) auto_d = 1'b0;
    if (auto_stop_issue) auto_d = 1'b1;

    // busy window opens once the command phase is over
    if (busy_q && (own_rsp || (own_end && ctx_q.rsp_none))) barm_d = 1'b1;
    if (barm_q && idle_done) begin
      busy_d = 1'b0;
      barm_d = 1'b0;
    end

    if (cmd_issue) begin
      cmdi_d         = 1'b1;
      ctx_d.rsp_none = (cmd_rsp_type == RSP_TYPE_NONE);
      ctx_d.kind     = xfer_kind_e'(cmd_kind);
      busy_d         = cmd_busy;
      barm_d         = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctx_q  <= '0;
      cmdi_q <= 1'b0;
      auto_q <= 1'b0;
      busy_q <= 1'b0;
      barm_q <= 1'b0;
    end else if (soft_rst) begin
      ctx_q  <= '0;
      cmdi_q <= 1'b0;
      auto_q <= 1'b0;
      busy_q <= 1'b0;
      barm_q <= 1'b0;
    end else begin
      ctx_q  <= ctx_d;
      cmdi_q <= cmdi_d;
      auto_q <= auto_d;
      busy_q <= busy_d;
      barm_q <= barm_d;
    end
  end

  assign cmd_inhibit = cmdi_q;
  assign busy_pend   = busy_q;
  assign busy_arm    = barm_q;
  assign start_rd    = own_end && (ctx_q.kind == KIND_RD);
  assign start_wr    = own_end && (ctx_q.kind == KIND_WR);

endmodule

// File: rtl/lit_data_track.sv
module lit_data_track
  import lit_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic start_rd,
  input  logic start_wr,
  input  logic rd_last_blk,
  input  logic rd_drained,
  input  logic wr_crc_stat,
  input  logic rd_wait,
  input  logic stop_gap,
  input  logic cont_req,
  input  logic idle_done,
  output logic rd_active,
  output logic wr_active,
  output logic dat_active,
  output logic dl_wait
);

  dl_state_e dl_q, dl_d;
  logic      rta_q, rta_d;
  logic      wta_q, wta_d;
  logic      dirw_q, dirw_d;
  logic      gap_q, gap_d;
  logic      busy_any;

  assign busy_any = rta_q || wta_q || (dl_q != DL_OFF);

  always_comb begin
    dl_d   = dl_q;
    rta_d  = rta_q;
    wta_d  = wta_q;
    dirw_d = dirw_q;
    gap_d  = gap_q;

    if (dl_q == DL_WAIT && idle_done) dl_d = DL_OFF;

    if (start_rd) begin
      rta_d  = 1'b1;
      dl_d   = DL_ON;
      dirw_d = 1'b0;
      gap_d  = 1'b0;
    end else if (start_wr) begin
      wta_d  = 1'b1;
      dl_d   = DL_ON;
      dirw_d = 1'b1;
      gap_d  = 1'b0;
    end else if (cont_req && gap_q) begin
      gap_d = 1'b0;
      dl_d  = DL_ON;
      if (dirw_q) wta_d = 1'b1;
      else        rta_d = 1'b1;
    end else if (stop_gap && busy_any) begin
      gap_d = 1'b1;
      rta_d = 1'b0;
      wta_d = 1'b0;
      if (dl_q == DL_ON) dl_d = dirw_q ? DL_WAIT : DL_OFF;
    end else begin
      if (rd_drained) rta_d = 1'b0;
      if (wr_crc_stat && wta_q) begin
        wta_d = 1'b0;
        if (dl_q == DL_ON) dl_d = DL_WAIT;
      end
      if (!dirw_q && dl_q == DL_ON && (rd_last_blk || rd_wait)) dl_d = DL_OFF;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dl_q   <= DL_OFF;
      rta_q  <= 1'b0;
      wta_q  <= 1'b0;
      dirw_q <= 1'b0;
      gap_q  <= 1'b0;
    end else if (soft_rst) begin
      dl_q   <= DL_OFF;
      rta_q  <= 1'b0;
      wta_q  <= 1'b0;
      dirw_q <= 1'b0;
      gap_q  <= 1'b0;
    end else begin
      dl_q   <= dl_d;
      rta_q  <= rta_d;
      wta_q  <= wta_d;
      dirw_q <= dirw_d;
      gap_q  <= gap_d;
    end
  end

  assign rd_active  = rta_q;
  assign wr_active  = wta_q;
  assign dat_active = (dl_q != DL_OFF);
  assign dl_wait    = (dl_q == DL_WAIT);

endmodule

// File: rtl/line_inhibit_tracker.sv
module line_inhibit_tracker #(
  parameter int IDLE_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_rst,
  input  logic       cmd_issue,
  input  logic [1:0] cmd_rsp_type,
  input  logic [1:0] cmd_kind,
  input  logic       cmd_busy,
  input  logic       auto_stop_issue,
  input  logic       cmd_end,
  input  logic       rsp_end,
  input  logic       rsp_crc_err,
  input  logic       rsp_endbit_err,
  input  logic       auto_stop_skip,
  input  logic       cmd_timeout,
  input  logic       rd_last_blk,
  input  logic       rd_drained,
  input  logic       wr_crc_stat,
  input  logic       rd_wait,
  input  logic       stop_gap,
  input  logic       cont_req,
  input  logic       dat0,
  output logic       cmd_inhibit,
  output logic       rd_active,
  output logic       wr_active,
  output logic       dat_active,
  output logic       dat_inhibit,
  output logic       xfer_done
);

  logic busy_pend, busy_arm, start_rd, start_wr;
  logic dl_wait, idle_done, timer_arm;
  logic dati, dati_q, dati_d;

  lit_cmd_track u_cmd (
    .clk             (clk),
    .rst_n           (rst_n),
    .soft_rst        (soft_rst),
    .cmd_issue       (cmd_issue),
    .cmd_rsp_type    (cmd_rsp_type),
    .cmd_kind        (cmd_kind),
    .cmd_busy        (cmd_busy),
    .auto_stop_issue (auto_stop_issue),
    .cmd_end         (cmd_end),
    .rsp_end         (rsp_end),
    .rsp_crc_err     (rsp_crc_err),
    .rsp_endbit_err  (rsp_endbit_err),
    .auto_stop_skip  (auto_stop_skip),
    .cmd_timeout     (cmd_timeout),
    .idle_done       (idle_done),
    .cmd_inhibit     (cmd_inhibit),
    .busy_pend       (busy_pend),
    .busy_arm        (busy_arm),
    .start_rd        (start_rd),
    .start_wr        (start_wr)
  );

  lit_data_track u_data (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst    (soft_rst),
    .start_rd    (start_rd),
    .start_wr    (start_wr),
    .rd_last_blk (rd_last_blk),
    .rd_drained  (rd_drained),
    .wr_crc_stat (wr_crc_stat),
    .rd_wait     (rd_wait),
    .stop_gap    (stop_gap),
    .cont_req    (cont_req),
    .idle_done   (idle_done),
    .rd_active   (rd_active),
    .wr_active   (wr_active),
    .dat_active  (dat_active),
    .dl_wait     (dl_wait)
  );

  // one release window shared by write busy and busy-signalling commands
  assign timer_arm = dl_wait || busy_arm;

  lit_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .arm       (timer_arm),
    .dat0      (dat0),
    .idle_done (idle_done)
  );

  assign dati = dat_active || rd_active || busy_pend;

  always_comb begin
    dati_d = soft_rst ? 1'b0 : dati;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dati_q <= 1'b0;
    else        dati_q <= dati_d;
  end

  assign dat_inhibit = dati;
  assign xfer_done   = dati_q && !dati;

endmodule

// File: rtl/lit_checker.sv
module lit_checker (
  input logic clk,
  input logic rst_n,
  input logic soft_rst,
  input logic cmd_issue,
  input logic auto_stop_issue,
  input logic cmd_timeout,
  input logic cmd_end,
  input logic rsp_end,
  input logic dat0,
  input logic cmd_inhibit,
  input logic dat_active,
  input logic dat_inhibit,
  input logic xfer_done,
  input logic dl_wait
);

  assert_soft_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!cmd_inhibit && !dat_inhibit && !xfer_done));

  assert_issue_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_issue && !soft_rst) |=> cmd_inhibit);

  assert_auto_no_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_stop_issue && !cmd_issue && !cmd_inhibit && !soft_rst) |=> !cmd_inhibit);

  assert_timeout_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_inhibit && cmd_timeout && !rsp_end && !cmd_end && !soft_rst) |=> cmd_inhibit);

  assert_busy_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dl_wait && !dat0 && !soft_rst) |=> dat_active);

  assert_done_on_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> ($past(dat_inhibit) && !dat_inhibit));

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done);

endmodule

bind line_inhibit_tracker lit_checker u_lit_checker (
  .clk             (clk),
  .rst_n           (rst_n),
  .soft_rst        (soft_rst),
  .cmd_issue       (cmd_issue),
  .auto_stop_issue (auto_stop_issue),
  .cmd_timeout     (cmd_timeout),
  .cmd_end         (cmd_end),
  .rsp_end         (rsp_end),
  .dat0            (dat0),
  .cmd_inhibit     (cmd_inhibit),
  .dat_active      (dat_active),
  .dat_inhibit     (dat_inhibit),
  .xfer_done       (xfer_done),
  .dl_wait         (dl_wait)
);

// File: tb/line_inhibit_tracker_tb.sv
`timescale 1ns/1ps
module line_inhibit_tracker_tb;

  logic clk = 1'b0;
  logic rst_n;
  logic soft_rst, cmd_issue, cmd_busy, auto_stop_issue, cmd_end, rsp_end;
  logic rsp_crc_err, rsp_endbit_err, auto_stop_skip, cmd_timeout;
  logic rd_last_blk, rd_drained, wr_crc_stat, rd_wait, stop_gap, cont_req, dat0;
  logic [1:0] cmd_rsp_type, cmd_kind;
  logic cmd_inhibit, rd_active, wr_active, dat_active, dat_inhibit, xfer_done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  line_inhibit_tracker #(.IDLE_CYCLES(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cmd_issue(cmd_issue),
    .cmd_rsp_type(cmd_rsp_type), .cmd_kind(cmd_kind), .cmd_busy(cmd_busy),
    .auto_stop_issue(auto_stop_issue), .cmd_end(cmd_end), .rsp_end(rsp_end),
    .rsp_crc_err(rsp_crc_err), .rsp_endbit_err(rsp_endbit_err),
    .auto_stop_skip(auto_stop_skip), .cmd_timeout(cmd_timeout),
    .rd_last_blk(rd_last_blk), .rd_drained(rd_drained), .wr_crc_stat(wr_crc_stat),
    .rd_wait(rd_wait), .stop_gap(stop_gap), .cont_req(cont_req), .dat0(dat0),
    .cmd_inhibit(cmd_inhibit), .rd_active(rd_active), .wr_active(wr_active),
    .dat_active(dat_active), .dat_inhibit(dat_inhibit), .xfer_done(xfer_done)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] rtype, input logic [1:0] kind, input logic busy);
    cmd_rsp_type = rtype; cmd_kind = kind; cmd_busy = busy;
    cmd_issue = 1'b1; tick(); cmd_issue = 1'b0; cmd_busy = 1'b0;
  endtask

  task automatic pulse_end();  cmd_end = 1'b1; tick(); cmd_end = 1'b0; endtask
  task automatic pulse_rsp();  rsp_end = 1'b1; tick(); rsp_end = 1'b0; endtask

  task automatic t_reset();
    chk("R1", "cmd_inhibit after reset", cmd_inhibit, 1'b0);
    chk("R1", "dat_inhibit after reset", dat_inhibit, 1'b0);
    chk("R1", "rd/wr/dat active after reset", rd_active | wr_active | dat_active, 1'b0);
    chk("R1", "xfer_done after reset", xfer_done, 1'b0);
  endtask

  task automatic t_cmd_basic();
    issue(2'b01, 2'b00, 1'b0);
    chk("R2", "issue sets inhibit", cmd_inhibit, 1'b1);
    pulse_end();
    chk("R4", "cmd_end keeps inhibit when response expected", cmd_inhibit, 1'b1);
    pulse_rsp();
    chk("R3", "clean response clears inhibit", cmd_inhibit, 1'b0);
    chk("R10", "no data command leaves dat_inhibit low", dat_inhibit, 1'b0);
  endtask

  task automatic t_cmd_errors();
    for (int e = 0; e < 3; e++) begin
      issue(2'b10, 2'b00, 1'b0);
      rsp_crc_err = (e == 0); rsp_endbit_err = (e == 1); auto_stop_skip = (e == 2);
      rsp_end = 1'b1; tick(); rsp_end = 1'b0;
      rsp_crc_err = 1'b0; rsp_endbit_err = 1'b0; auto_stop_skip = 1'b0;
      chk("R3", $sformatf("error kind %0d keeps inhibit", e), cmd_inhibit, 1'b1);
      pulse_rsp();
      chk("R3", "later clean response clears", cmd_inhibit, 1'b0);
    end
  endtask

  task automatic t_no_rsp();
    issue(2'b00, 2'b00, 1'b0);
    chk("R2", "issue sets inhibit (no response)", cmd_inhibit, 1'b1);
    pulse_end();
    chk("R4", "cmd_end clears inhibit with type 00", cmd_inhibit, 1'b0);
  endtask

  task automatic t_timeout();
    issue(2'b01, 2'b00, 1'b0);
    cmd_timeout = 1'b1; tick(); cmd_timeout = 1'b0;
    chk("R5", "timeout keeps inhibit", cmd_inhibit, 1'b1);
    repeat (4) tick();
    chk("R5", "inhibit still set later", cmd_inhibit, 1'b1);
    soft_rst = 1'b1; tick(); soft_rst = 1'b0;
    chk("R1", "soft reset clears inhibit", cmd_inhibit, 1'b0);
  endtask

  task automatic t_auto_stop();
    auto_stop_issue = 1'b1; tick(); auto_stop_issue = 1'b0;
    chk("R2", "auto stop does not set inhibit", cmd_inhibit, 1'b0);
    pulse_rsp();
    chk("R3", "auto stop response leaves inhibit low", cmd_inhibit, 1'b0);
    issue(2'b01, 2'b00, 1'b0);
    auto_stop_issue = 1'b1; tick(); auto_stop_issue = 1'b0;
    pulse_rsp();
    chk("R3", "auto stop response does not clear normal inhibit", cmd_inhibit, 1'b1);
    pulse_rsp();
    chk("R3", "own response then clears", cmd_inhibit, 1'b0);
  endtask

  task automatic t_read();
    issue(2'b01, 2'b01, 1'b0);
    pulse_end();
    chk("R6", "read sets rd_active", rd_active, 1'b1);
    chk("R6", "read sets dat_active", dat_active, 1'b1);
    chk("R10", "read raises dat_inhibit", dat_inhibit, 1'b1);
    pulse_rsp();
    rd_last_blk = 1'b1; tick(); rd_last_blk = 1'b0;
    chk("R7", "last block clears dat_active", dat_active, 1'b0);
    chk("R7", "rd_active held until drained", rd_active, 1'b1);
    chk("R11", "no done while rd_active", xfer_done, 1'b0);
    rd_drained = 1'b1; tick(); rd_drained = 1'b0;
    chk("R7", "drain clears rd_active", rd_active, 1'b0);
    chk("R11", "done pulse on release", xfer_done, 1'b1);
    tick();
    chk("R11", "done lasts one cycle", xfer_done, 1'b0);
    issue(2'b01, 2'b01, 1'b0);
    pulse_end();
    rd_wait = 1'b1; tick(); rd_wait = 1'b0;
    chk("R7", "read-wait clears dat_active", dat_active, 1'b0);
    rd_drained = 1'b1; tick(); rd_drained = 1'b0;
    pulse_rsp();
  endtask

  task automatic t_write();
    dat0 = 1'b0;
    issue(2'b01, 2'b10, 1'b0);
    pulse_end();
    chk("R6", "write sets wr_active", wr_active, 1'b1);
    chk("R6", "write sets dat_active", dat_active, 1'b1);
    pulse_rsp();
    wr_crc_stat = 1'b1; tick(); wr_crc_stat = 1'b0;
    chk("R8", "crc status clears wr_active", wr_active, 1'b0);
    chk("R8", "dat_active held during busy", dat_active, 1'b1);
    repeat (3) tick();
    chk("R8", "dat_active held while line low", dat_active, 1'b1);
    dat0 = 1'b1; repeat (4) tick();
    dat0 = 1'b0; tick();
    dat0 = 1'b1; repeat (7) tick();
    chk("R8", "seven idle samples after glitch not enough", dat_active, 1'b1);
    chk("R11", "no done before release", xfer_done, 1'b0);
    tick();
    chk("R8", "eighth idle sample releases", dat_active, 1'b0);
    chk("R11", "done on write release", xfer_done, 1'b1);
    tick();
    chk("R11", "write done one cycle", xfer_done, 1'b0);
  endtask

  task automatic t_gap();
    dat0 = 1'b1;
    issue(2'b01, 2'b01, 1'b0);
    pulse_end(); pulse_rsp();
    stop_gap = 1'b1; tick(); stop_gap = 1'b0;
    chk("R7", "gap stop clears rd_active", rd_active, 1'b0);
    chk("R7", "gap stop clears read dat_active", dat_active, 1'b0);
    cont_req = 1'b1; tick(); cont_req = 1'b0;
    chk("R9", "continue re-sets rd_active", rd_active, 1'b1);
    chk("R9", "continue re-sets dat_active", dat_active, 1'b1);
    rd_last_blk = 1'b1; tick(); rd_last_blk = 1'b0;
    rd_drained = 1'b1; tick(); rd_drained = 1'b0;
    cont_req = 1'b1; tick(); cont_req = 1'b0;
    chk("R9", "continue without stop ignored (rd)", rd_active, 1'b0);
    chk("R9", "continue without stop ignored (dat)", dat_active, 1'b0);
    issue(2'b01, 2'b10, 1'b0);
    pulse_end(); pulse_rsp();
    stop_gap = 1'b1; tick(); stop_gap = 1'b0;
    chk("R8", "gap stop clears wr_active", wr_active, 1'b0);
    repeat (7) tick();
    chk("R8", "write gap waits idle window", dat_active, 1'b1);
    tick();
    chk("R8", "write gap releases after window", dat_active, 1'b0);
    cont_req = 1'b1; tick(); cont_req = 1'b0;
    chk("R9", "continue re-sets wr_active", wr_active, 1'b1);
    wr_crc_stat = 1'b1; tick(); wr_crc_stat = 1'b0;
    repeat (8) tick();
    chk("R8", "write ends after window", dat_active, 1'b0);
  endtask

  task automatic t_busy_cmd();
    dat0 = 1'b0;
    issue(2'b01, 2'b00, 1'b1);
    chk("R10", "busy command raises dat_inhibit", dat_inhibit, 1'b1);
    pulse_rsp();
    chk("R3", "busy command response clears cmd_inhibit", cmd_inhibit, 1'b0);
    repeat (3) tick();
    chk("R10", "busy pending while line low", dat_inhibit, 1'b1);
    dat0 = 1'b1; repeat (7) tick();
    chk("R10", "busy pending before window ends", dat_inhibit, 1'b1);
    tick();
    chk("R10", "busy released after window", dat_inhibit, 1'b0);
    chk("R11", "done on busy release", xfer_done, 1'b1);
  endtask

  task automatic t_soft();
    issue(2'b01, 2'b01, 1'b0);
    pulse_end();
    chk("R6", "read active before soft reset", dat_inhibit, 1'b1);
    soft_rst = 1'b1; tick(); soft_rst = 1'b0;
    chk("R1", "soft reset clears rd_active", rd_active, 1'b0);
    chk("R1", "soft reset clears dat_inhibit", dat_inhibit, 1'b0);
    chk("R1", "soft reset clears cmd_inhibit", cmd_inhibit, 1'b0);
    chk("R1", "soft reset gives no done", xfer_done, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; soft_rst = 1'b0; cmd_issue = 1'b0; cmd_busy = 1'b0;
    auto_stop_issue = 1'b0; cmd_end = 1'b0; rsp_end = 1'b0;
    rsp_crc_err = 1'b0; rsp_endbit_err = 1'b0; auto_stop_skip = 1'b0;
    cmd_timeout = 1'b0; rd_last_blk = 1'b0; rd_drained = 1'b0;
    wr_crc_stat = 1'b0; rd_wait = 1'b0; stop_gap = 1'b0; cont_req = 1'b0;
    dat0 = 1'b1; cmd_rsp_type = 2'b00; cmd_kind = 2'b00;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_cmd_basic();
    t_cmd_errors();
    t_no_rsp();
    t_timeout();
    t_auto_stop();
    t_read();
    t_write();
    t_gap();
    t_busy_cmd();
    t_soft();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule